// File: doc/BRIEF.md
# Per-Lane Termination Detect Sequencer

This controller manages the line terminations of a four-lane high-speed repeater. Each lane has its own detection state machine. After reset, while the global power-enable is low, and while a lane is held back by its register controls, the lane keeps both terminations at their high-impedance values: 200 kohm on the input and 2 kohm on the output. When the lane is released, it enables an external far-end-load comparator and polls it in fixed timed windows. A window normally lasts 5 ms. The lane keeps opening new windows until a 50 ohm load is reported. It then switches its input to 50 ohm and, if its enable bit is set, turns on the output driver with the low output termination.

A detected lane also squelches its driver to common mode while the signal activity comparator reports that the input has fallen below the de-assert threshold. It resumes once the input rises above the assert threshold. The squelch state is exported as a per-lane activity flag. Register bits can bypass the squelch, power down the detector, or restart detection on any single lane.

The window length is the product of two parameters: a prescaler in system clock cycles and a count of prescaler ticks. A real 5 ms window and a short simulation window therefore use the same logic.

Top module: `term_detect_seq`

## Requirements
- R1: After reset, and in every cycle after one in which `pwr_en` is low, every lane is idle: `rx_term_low`, `tx_term_low`, `drv_en`, `probe_en`, `mute` and `act_flag` are all 0.
- R2: An idle lane whose hold condition (`pwr_en` low, `det_pd` bit high or `rx_rst` bit high) is false at a clock edge enters detection at that edge and drives `probe_en` high. A rising edge of `pwr_en` therefore starts detection on every released lane.
- R3: A detection window lasts exactly PRESCALE*WINDOW_TICKS cycles, counted from entry into detection. `load_seen` is taken into account only in the last cycle of a window; a 1 there marks the lane as detected at the closing edge.
- R4: If `load_seen` is 0 in the last cycle of a window, a new full window starts at once. Retries continue without limit while `probe_en` stays high.
- R5: A detected lane drives `rx_term_low` high (50 ohm input termination) and `probe_en` low, and stays detected until its hold condition becomes true.
- R6: `drv_en` and `tx_term_low` (1 = 50 ohm output termination) equal "lane detected AND `lane_en` bit" in the same cycle.
- R7: While a lane's `det_pd` bit is 1, that lane stays idle with `probe_en` low and high-impedance terminations.
- R8: A lane's `rx_rst` bit being 1 sends only that lane to idle. On release it restarts detection with a fresh full window.
- R9: For a detected lane with squelch bypass off, `sig_below` high sets `mute` at the next edge, `sig_above` high (with `sig_below` low) clears it at the next edge, and with both low `mute` holds its value. `sig_below` wins when both are high.
- R10: `mute` is 0 in the cycle after `act_dis` was 1 for that lane, and whenever the lane is not detected.
- R11: `act_flag` is 1 exactly when the lane is detected and `mute` is 0.
- R12: Each lane's detection, terminations and squelch depend only on its own bits of the per-lane inputs, apart from the shared `pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Global power enable; low forces all lanes idle |
| lane_en | input | NUM_LANES | Per-lane enable register bit |
| det_pd | input | NUM_LANES | Per-lane detector power-down bit |
| rx_rst | input | NUM_LANES | Per-lane receiver reset bit |
| act_dis | input | NUM_LANES | Per-lane squelch bypass bit (1 = bypass) |
| load_seen | input | NUM_LANES | Far-end 50 ohm load comparator result |
| sig_below | input | NUM_LANES | Activity comparator: input below de-assert threshold |
| sig_above | input | NUM_LANES | Activity comparator: input above assert threshold |
| rx_term_low | output | NUM_LANES | 1 = 50 ohm input termination, 0 = 200 kohm |
| tx_term_low | output | NUM_LANES | 1 = 50 ohm output termination, 0 = 2 kohm |
| probe_en | output | NUM_LANES | Enable for the far-end load comparator |
| drv_en | output | NUM_LANES | Output driver enable |
| mute | output | NUM_LANES | 1 = driver squelched to common mode |
| act_flag | output | NUM_LANES | Activity status: detected and not squelched |

## Verification
The bench builds the block with PRESCALE=3 and WINDOW_TICKS=4, so one detection window is 12 cycles rather than hundreds of thousands. This makes window boundaries, repeated retries and restarts after power-down or lane reset reachable many times within a short run. A prescaler above 1 together with a tick count above 1 means both counter levels wrap, so an error in either one shifts the detection edge that the bench checks.

// File: rtl/tdet_pkg.sv
package tdet_pkg;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_SEEK  = 2'd1,
        LN_FOUND = 2'd2
    } lane_st_e;

    typedef struct packed {
        lane_st_e st;
        logic     mute;
    } lane_reg_t;

endpackage

// File: rtl/tdet_window.sv
module tdet_window #(
    parameter int PRESCALE     = 1000,
    parameter int WINDOW_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TICK_W = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRESCALE - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(WINDOW_TICKS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [TICK_W-1:0] tick;
    } win_t;

    win_t win_d, win_q;
    logic pre_wrap;

    always_comb begin
        win_d    = win_q;
        pre_wrap = (win_q.pre == PRE_LAST);
        done_o   = run_i && pre_wrap && (win_q.tick == TICK_LAST);
        if (!run_i) begin
            win_d = '0;
        end else if (pre_wrap) begin
            win_d.pre  = '0;
            win_d.tick = (win_q.tick == TICK_LAST) ? '0 : win_q.tick + 1'b1;
        end else begin
            win_d.pre = win_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // R3
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.tick <= TICK_LAST) && (win_q.pre <= PRE_LAST));

    // R3
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (win_q == '0));

endmodule

// File: rtl/tdet_lane.sv
module tdet_lane
    import tdet_pkg::*;
#(
    parameter int PRESCALE     = 1000,
    parameter int WINDOW_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en_i,
    input  logic en_i,
    input  logic pd_i,
    input  logic rst_i,
    input  logic act_dis_i,
    input  logic load_i,
    input  logic below_i,
    input  logic above_i,
    output logic rx_term_low_o,
    output logic tx_term_low_o,
    output logic probe_o,
    output logic drv_o,
    output logic mute_o,
    output logic act_o
);
    lane_reg_t lane_d, lane_q;
    logic      hold;
    logic      run;
    logic      win_done;

    assign hold = !pwr_en_i || pd_i || rst_i;
    assign run  = (lane_q.st == LN_SEEK) && !hold;

    tdet_window #(
        .PRESCALE    (PRESCALE),
        .WINDOW_TICKS(WINDOW_TICKS)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .done_o(win_done)
    );

    always_comb begin
        lane_d = lane_q;
        if (hold) begin
            lane_d.st = LN_IDLE;
        end else begin
            unique case (lane_q.st)
                LN_IDLE:  lane_d.st = LN_SEEK;
                LN_SEEK:  if (win_done && load_i) lane_d.st = LN_FOUND;
                LN_FOUND: lane_d.st = LN_FOUND;
                default:  lane_d.st = LN_IDLE;
            endcase
        end

        if (lane_d.st != LN_FOUND || act_dis_i) begin
            lane_d.mute = 1'b0;
        end else if (below_i) begin
            lane_d.mute = 1'b1;
        end else if (above_i) begin
            lane_d.mute = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q.st   <= LN_IDLE;
            lane_q.mute <= 1'b0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign rx_term_low_o = (lane_q.st == LN_FOUND);
    assign probe_o       = (lane_q.st == LN_SEEK);
    assign drv_o         = rx_term_low_o && en_i;
    assign tx_term_low_o = drv_o;
    assign mute_o        = lane_q.mute;
    assign act_o         = rx_term_low_o && !lane_q.mute;

    // R1
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_i |=> (!rx_term_low_o && !probe_o && !drv_o && !mute_o));

    // R3
    early_find_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_o && !win_done) |=> !rx_term_low_o);

    // R4
    retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_o && win_done && !load_i && !hold) |=> probe_o);

    // R9
    mute_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_term_low_o && !hold && !act_dis_i && below_i) |=> mute_o);

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_dis_i |=> !mute_o);

endmodule

// File: rtl/term_detect_seq.sv
module term_detect_seq #(
    parameter int NUM_LANES    = 4,
    parameter int PRESCALE     = 1000,
    parameter int WINDOW_TICKS = 500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_en,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [NUM_LANES-1:0] det_pd,
    input  logic [NUM_LANES-1:0] rx_rst,
    input  logic [NUM_LANES-1:0] act_dis,
    input  logic [NUM_LANES-1:0] load_seen,
    input  logic [NUM_LANES-1:0] sig_below,
    input  logic [NUM_LANES-1:0] sig_above,
    output logic [NUM_LANES-1:0] rx_term_low,
    output logic [NUM_LANES-1:0] tx_term_low,
    output logic [NUM_LANES-1:0] probe_en,
    output logic [NUM_LANES-1:0] drv_en,
    output logic [NUM_LANES-1:0] mute,
    output logic [NUM_LANES-1:0] act_flag
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        tdet_lane #(
            .PRESCALE    (PRESCALE),
            .WINDOW_TICKS(WINDOW_TICKS)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .pwr_en_i     (pwr_en),
            .en_i         (lane_en[g]),
            .pd_i         (det_pd[g]),
            .rst_i        (rx_rst[g]),
            .act_dis_i    (act_dis[g]),
            .load_i       (load_seen[g]),
            .below_i      (sig_below[g]),
            .above_i      (sig_above[g]),
            .rx_term_low_o(rx_term_low[g]),
            .tx_term_low_o(tx_term_low[g]),
            .probe_o      (probe_en[g]),
            .drv_o        (drv_en[g]),
            .mute_o       (mute[g]),
            .act_o        (act_flag[g])
        );
    end

    // R6
    drv_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en & ~rx_term_low) == '0);

endmodule

// File: tb/term_detect_seq_tb.sv
module term_detect_seq_tb;
    localparam int  N        = 4;
    localparam int  PRE      = 3;
    localparam int  TICKS    = 4;
    localparam int  W        = PRE * TICKS;
    localparam time CLK_PER  = 10ns;

    logic clk = 1'b0;
    logic rst_n;
    logic pwr_en;
    logic [N-1:0] lane_en, det_pd, rx_rst, act_dis, load_seen, sig_below, sig_above;
    logic [N-1:0] rx_term_low, tx_term_low, probe_en, drv_en, mute, act_flag;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // bench reference model: 0 idle, 1 seeking, 2 detected
    int m_st  [N];
    int m_cnt [N];
    bit m_mute[N];

    always #(CLK_PER/2) clk = ~clk;

    term_detect_seq #(
        .NUM_LANES   (N),
        .PRESCALE    (PRE),
        .WINDOW_TICKS(TICKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .lane_en(lane_en),
        .det_pd(det_pd), .rx_rst(rx_rst), .act_dis(act_dis),
        .load_seen(load_seen), .sig_below(sig_below), .sig_above(sig_above),
        .rx_term_low(rx_term_low), .tx_term_low(tx_term_low),
        .probe_en(probe_en), .drv_en(drv_en), .mute(mute), .act_flag(act_flag)
    );

    function automatic int next_state(int st, int cnt, bit hold, bit load);
        if (hold) return 0;
        if (st == 0) return 1;
        if (st == 1) return (cnt == W - 1 && load) ? 2 : 1;
        return 2;
    endfunction

    function automatic bit next_mute(int nst, bit cur, bit dis, bit below, bit above);
        if (nst != 2 || dis) return 1'b0;
        if (below) return 1'b1;
        if (above) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_st[i] = 0; m_cnt[i] = 0; m_mute[i] = 1'b0;
            end else begin
                bit h;
                int ns;
                h  = !pwr_en || det_pd[i] || rx_rst[i];
                ns = next_state(m_st[i], m_cnt[i], h, load_seen[i]);
                m_mute[i] = next_mute(ns, m_mute[i], act_dis[i], sig_below[i], sig_above[i]);
                if (ns == 1 && m_st[i] == 1) m_cnt[i] = (m_cnt[i] == W - 1) ? 0 : m_cnt[i] + 1;
                else                         m_cnt[i] = 0;
                m_st[i] = ns;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < N; i++) begin
            bit det;
            det = (m_st[i] == 2);
            chk("R4 probe_en",    32'(probe_en[i]),    32'(m_st[i] == 1));
            chk("R5 rx_term_low", 32'(rx_term_low[i]), 32'(det));
            chk("R6 drv_en",      32'(drv_en[i]),      32'(det && lane_en[i]));
            chk("R6 tx_term_low", 32'(tx_term_low[i]), 32'(det && lane_en[i]));
            chk("R9 mute",        32'(mute[i]),        32'(m_mute[i]));
            chk("R11 act_flag",   32'(act_flag[i]),    32'(det && !m_mute[i]));
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic rand_inputs();
        if (pwr_en) begin
            if ($urandom_range(0, 299) == 0) pwr_en = 1'b0;
        end else if ($urandom_range(0, 9) == 0) pwr_en = 1'b1;
        for (int i = 0; i < N; i++) begin
            if ($urandom_range(0, 149) == 0) det_pd[i]  = ~det_pd[i];
            if ($urandom_range(0, 49)  == 0) lane_en[i] = ~lane_en[i];
            if ($urandom_range(0, 79)  == 0) act_dis[i] = ~act_dis[i];
            rx_rst[i]    = ($urandom_range(0, 199) == 0);
            load_seen[i] = ($urandom_range(0, 7) == 0);
            sig_below[i] = ($urandom_range(0, 5) == 0);
            sig_above[i] = ($urandom_range(0, 5) == 0);
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; pwr_en = 1'b0;
        lane_en = '1; det_pd = '0; rx_rst = '0; act_dis = '0;
        load_seen = '0; sig_below = '0; sig_above = '0;
        step(3);
        // R1 reset state
        chk("R1 reset terms", 32'({rx_term_low, tx_term_low, probe_en, drv_en}), 32'h0);
        chk("R1 reset mute",  32'({mute, act_flag}), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        step(2);
        chk("R1 pwr low idle", 32'({rx_term_low, probe_en}), 32'h0);

        // R2 / R3: rising power enable, load present from the start
        load_seen = '1; pwr_en = 1'b1;
        step(1);
        chk("R2 probe after pwr rise", 32'(probe_en), 32'hF);
        step(W - 1);
        chk("R3 not found before window end", 32'(rx_term_low), 32'h0);
        step(1);
        chk("R3 found at window end", 32'(rx_term_low), 32'hF);
        chk("R5 probe off when found", 32'(probe_en), 32'h0);

        // R1 power down, then R4 retries
        pwr_en = 1'b0;
        step(1);
        chk("R1 pwr off clears", 32'({rx_term_low, drv_en}), 32'h0);
        load_seen = '0; pwr_en = 1'b1;
        step(2 * W);
        chk("R4 still probing after two windows", 32'(probe_en), 32'hF);
        chk("R4 no detect without load", 32'(rx_term_low), 32'h0);
        load_seen = 4'b0101;
        step(W + 1);
        chk("R12 only loaded lanes detect", 32'(rx_term_low), 32'h5);
        chk("R4 unloaded lanes keep probing", 32'(probe_en), 32'hA);
        load_seen = '1;
        step(W + 2);
        chk("R4 late detect", 32'(rx_term_low), 32'hF);

        // R7 detector power-down on lane 1
        det_pd[1] = 1'b1;
        step(3);
        chk("R7 pd lane idle", 32'({rx_term_low[1], probe_en[1], drv_en[1]}), 32'h0);
        chk("R12 others unaffected", 32'(rx_term_low), 32'hD);
        det_pd[1] = 1'b0;
        step(W + 1);
        chk("R7 release redetects", 32'(rx_term_low[1]), 32'h1);

        // R8 receiver reset on lane 2
        rx_rst[2] = 1'b1;
        step(1);
        rx_rst[2] = 1'b0;
        chk("R8 reset lane idle", 32'({rx_term_low[2], probe_en[2]}), 32'h0);
        chk("R12 reset isolated", 32'(rx_term_low), 32'hB);
        step(W);
        chk("R8 fresh window not done", 32'(rx_term_low[2]), 32'h0);
        step(1);
        chk("R8 fresh window done", 32'(rx_term_low[2]), 32'h1);

        // R6 lane enable gates driver
        lane_en[0] = 1'b0;
        step(1);
        chk("R6 drv off when disabled", 32'({drv_en[0], tx_term_low[0]}), 32'h0);
        chk("R6 input term kept", 32'(rx_term_low[0]), 32'h1);
        lane_en[0] = 1'b1;

        // R9 / R10 / R11 squelch on lane 3
        sig_below[3] = 1'b1;
        step(1);
        chk("R9 mute set", 32'(mute[3]), 32'h1);
        chk("R11 act low when muted", 32'(act_flag[3]), 32'h0);
        sig_below[3] = 1'b0;
        step(2);
        chk("R9 mute holds", 32'(mute[3]), 32'h1);
        sig_above[3] = 1'b1; sig_below[3] = 1'b1;
        step(1);
        chk("R9 below wins", 32'(mute[3]), 32'h1);
        sig_below[3] = 1'b0;
        step(1);
        chk("R9 mute clear", 32'(mute[3]), 32'h0);
        chk("R11 act high", 32'(act_flag[3]), 32'h1);
        sig_above[3] = 1'b0; sig_below[3] = 1'b1; act_dis[3] = 1'b1;
        step(2);
        chk("R10 bypass keeps unmuted", 32'(mute[3]), 32'h0);
        act_dis[3] = 1'b0; sig_below = '0;
        step(1);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            rand_inputs();
            step(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule